// File: doc/BRIEF.md
# CAN/LIN Physical Layer Control Register with CAN Mode Sequencer

This block holds the 16-bit control word that configures a CAN and a LIN physical-layer interface. It takes each control frame from a valid/ready stream, decodes its address field and two command bits, and returns one feedback word per addressed frame on a second valid/ready stream. A frame may only read, or read and overwrite the stored control bits. Frames that carry another address are consumed and dropped.

The block also sequences the CAN side through four states: off-line, on-line, listen-only on-line and active. A wake-up pulse brings the CAN side out of off-line. A bus idle timer returns it to off-line when no bus edge is seen for the selected time. That time is longer after a wake-up until the first bus edge arrives. The block clears the listen-only request when the CAN side enters on-line or active, and gates loopback and the transmitter. It also holds a hidden transmitter-disable latch that an interfacing fault sets. The system operating mode is an input.

Top module: `phy_ctrl_reg`

## Requirements
- R1: A frame whose bits 15:14 are not binary 11 is consumed, produces no response and leaves every control bit unchanged.
- R2: In an addressed frame, bit 12 = 1 means read only, and the stored control bits do not change. Bit 12 = 0 writes frame bits 11:0 into the control word. In both cases the response carries the contents from before the frame.
- R3: Bit 13 = 1 returns the `gp_status` input. Bit 13 = 0 returns {2'b11, 2'b00, control[11:0]}. The control layout from bit 11 down to bit 0 is: V2 keep-on, listen request, long idle select, CAN TX off, CAN loopback, CAN active, reserved, LIN active, LIN low slope, LIN high drive, LIN wake enable, LIN TX off.
- R4: The reserved control bit 5 always reads back as 0 and has no effect on any output.
- R5: Response stream: `resp_valid` and `resp_data` stay unchanged while `resp_ready` is low, and `frame_ready` is low while an unaccepted response is pending.
- R6: CAN active and LIN active take effect only while `sys_mode` is 2'b01 (normal) or 2'b10 (flash). `lin_tx_en` is LIN active and not LIN TX off. Outside those modes the CAN side leaves the active state on the next clock.
- R7: `can_state` is encoded as 0 off-line, 1 on-line, 2 listen, 3 active. A `bus_wake` pulse in off-line enters listen if the listen request is set, and on-line otherwise. Entering on-line or active clears the listen request.
- R8: `can_rxd_out` equals `can_txd` only when both CAN loopback and CAN TX off are 1. Otherwise it equals `bus_rxd`.
- R9: In on-line or listen, the CAN side enters off-line exactly N clocks after entering that state or after the last `bus_rxd` edge. N is T_SHORT when the long idle select bit is 0, and T_LONG when it is 1.
- R10: After a wake-up, N is T_SHORT_EXT or T_LONG_EXT until the first `bus_rxd` edge. That edge restarts the count with the normal period.
- R11: An `if_fault` pulse forces `can_tx_en` low without changing the stored CAN TX off bit. A `bus_ok` pulse releases the latch, and so does a write that changes CAN TX off from 1 to 0.
- R12: After reset the control word is 0, the CAN side is off-line, `can_tx_en`, `v2_en` and `resp_valid` are 0, and `frame_ready` is 1.
- R13: `v2_en` is 1 outside off-line, and is 1 in off-line only when the V2 keep-on bit is 1.
- R14: `can_tx_en` is 1 only in the active state with CAN TX off = 0 and no latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | Control frame offered |
| frame_ready | output | 1 | Control frame accepted when valid is also high |
| frame_data | input | 16 | Control frame: address, read select, read-only flag, control bits |
| resp_valid | output | 1 | Feedback word pending |
| resp_ready | input | 1 | Consumer takes the feedback word |
| resp_data | output | 16 | Feedback word |
| gp_status | input | 16 | General-purpose feedback word returned when bit 13 is set |
| sys_mode | input | 2 | System mode: 00 standby, 01 normal, 10 flash, 11 sleep |
| bus_wake | input | 1 | Single-cycle CAN wake-up pulse |
| bus_rxd | input | 1 | Received CAN bus level |
| bus_ok | input | 1 | Single-cycle pulse: correctly levelled CAN traffic received |
| if_fault | input | 1 | Single-cycle pulse: RXD/TXD interfacing fault |
| can_txd | input | 1 | Transmit data from the CAN controller |
| can_state | output | 2 | CAN state: 0 off-line, 1 on-line, 2 listen, 3 active |
| can_tx_en | output | 1 | CAN transmitter enable |
| can_rxd_out | output | 1 | Receive data to the CAN controller |
| v2_en | output | 1 | Secondary supply enable |
| lin_active | output | 1 | LIN active, mode-gated |
| lin_tx_en | output | 1 | LIN transmitter enable |
| lin_low_slope | output | 1 | LIN low-slope (low bit rate) setting |
| lin_hi_drive | output | 1 | LIN increased driver current |
| lin_wake_en | output | 1 | Wake-up through the LIN bus allowed |

## Verification
The assertions assume that `bus_wake`, `if_fault` and `bus_ok` are single-cycle pulses synchronous to `clk`. They also assume that `frame_data` is held while `frame_valid` waits for `frame_ready`, and that `sys_mode` changes only between edges. The stimulus keeps to these rules: every input changes at the falling clock edge, each pulse lasts one cycle, and the driver holds a frame until a falling-edge sample shows `frame_ready` high. Idle-timeout windows are measured from a known entry edge with no bus edges except the deliberate restart.

// File: rtl/phyc_pkg.sv
package phyc_pkg;
  localparam int FRAME_W = 16;
  localparam int CTL_W   = 12;
  localparam logic [1:0] ADDR_SEL = 2'b11;
  localparam int BIT_RO  = 12;
  localparam int BIT_RS  = 13;

  typedef struct packed {
    logic v2_keep;
    logic listen_req;
    logic off_long;
    logic can_tx_off;
    logic can_loop;
    logic can_act;
    logic rsvd;
    logic lin_act;
    logic lin_low_slope;
    logic lin_hi_drive;
    logic lin_wake_en;
    logic lin_tx_off;
  } ctl_t;

  typedef enum logic [1:0] {
    CS_OFFLINE = 2'd0,
    CS_ONLINE  = 2'd1,
    CS_LISTEN  = 2'd2,
    CS_ACTIVE  = 2'd3
  } can_st_e;
endpackage

// File: rtl/phyc_regs.sv
module phyc_regs
  import phyc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_valid,
  output logic               frm_ready,
  input  logic [FRAME_W-1:0] frm_data,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic [FRAME_W-1:0] resp_data,
  input  logic [FRAME_W-1:0] gp_status,
  input  logic               clr_listen,
  output ctl_t               ctl,
  output logic               wr_fire,
  output logic               txoff_fall
);
  ctl_t ctl_q;
  logic accept, hit, resp_gp_q;
  logic [FRAME_W-1:0] ctl_word;

  assign frm_ready  = !resp_valid || resp_ready;
  assign accept     = frm_valid && frm_ready;
  assign hit        = (frm_data[FRAME_W-1 -: 2] == ADDR_SEL);
  assign wr_fire    = accept && hit && !frm_data[BIT_RO];
  assign txoff_fall = wr_fire && ctl_q.can_tx_off && !frm_data[8];
  assign ctl_word   = {ADDR_SEL, 2'b00, ctl_q};
  assign ctl        = ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_fire) begin
      ctl_q      <= ctl_t'(frm_data[CTL_W-1:0]);
      ctl_q.rsvd <= 1'b0;
    end else if (clr_listen) begin
      ctl_q.listen_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_gp_q  <= 1'b0;
    end else if (accept && hit) begin
      resp_valid <= 1'b1;
      resp_gp_q  <= frm_data[BIT_RS];
      resp_data  <= frm_data[BIT_RS] ? gp_status : ctl_word;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data));

  p_ro_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit && frm_data[BIT_RO] && !clr_listen |=> $stable(ctl_q));

  p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_gp_q |-> resp_data[5] == 1'b0);
endmodule

// File: rtl/phyc_idle_timer.sv
module phyc_idle_timer #(
  parameter int T_SHORT     = 16,
  parameter int T_LONG      = 40,
  parameter int T_SHORT_EXT = 24,
  parameter int T_LONG_EXT  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bus_rxd,
  input  logic wake_set,
  input  logic off_long,
  output logic expire
);
  localparam int TMAX_A = (T_LONG > T_SHORT) ? T_LONG : T_SHORT;
  localparam int TMAX_B = (T_LONG_EXT > T_SHORT_EXT) ? T_LONG_EXT : T_SHORT_EXT;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int CW     = $clog2(TMAX + 1);

  logic [CW-1:0] cnt_q, lim;
  logic rxd_q, ext_q, activity;

  assign activity = (bus_rxd != rxd_q);

  always_comb begin
    case ({ext_q, off_long})
      2'b00:   lim = CW'(T_SHORT);
      2'b01:   lim = CW'(T_LONG);
      2'b10:   lim = CW'(T_SHORT_EXT);
      default: lim = CW'(T_LONG_EXT);
    endcase
  end

  assign expire = run && !activity && (cnt_q >= lim - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_q <= 1'b1;
      ext_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      rxd_q <= bus_rxd;
      if (wake_set)      ext_q <= 1'b1;
      else if (activity) ext_q <= 1'b0;
      if (!run || activity) cnt_q <= '0;
      else if (cnt_q < lim) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/phyc_can_seq.sv
module phyc_can_seq
  import phyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bus_wake,
  input  logic    mode_ok,
  input  logic    can_act,
  input  logic    listen_req,
  input  logic    expire,
  output can_st_e state,
  output logic    clr_listen,
  output logic    wake_enter
);
  can_st_e st_q, st_d;
  logic act_ok;

  assign act_ok = can_act && mode_ok;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CS_OFFLINE: if (bus_wake) st_d = listen_req ? CS_LISTEN : CS_ONLINE;
      CS_ONLINE: begin
        if (act_ok)          st_d = CS_ACTIVE;
        else if (expire)     st_d = CS_OFFLINE;
        else if (listen_req) st_d = CS_LISTEN;
      end
      CS_LISTEN: begin
        if (act_ok)      st_d = CS_ACTIVE;
        else if (expire) st_d = CS_OFFLINE;
      end
      CS_ACTIVE: if (!act_ok) st_d = CS_ONLINE;
      default: st_d = CS_OFFLINE;
    endcase
  end

  assign clr_listen = (st_d != st_q) && (st_d == CS_ONLINE || st_d == CS_ACTIVE);
  assign wake_enter = (st_q == CS_OFFLINE) && bus_wake;
  assign state      = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= CS_OFFLINE;
    else        st_q <= st_d;
  end

  p_mode_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |=> st_q != CS_ACTIVE);

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == CS_OFFLINE && bus_wake && !listen_req |=> st_q == CS_ONLINE);
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phyc_pkg::*;
#(
  parameter int T_SHORT     = 16,
  parameter int T_LONG      = 40,
  parameter int T_SHORT_EXT = 24,
  parameter int T_LONG_EXT  = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_valid,
  output logic        frame_ready,
  input  logic [15:0] frame_data,
  output logic        resp_valid,
  input  logic        resp_ready,
  output logic [15:0] resp_data,
  input  logic [15:0] gp_status,
  input  logic [1:0]  sys_mode,
  input  logic        bus_wake,
  input  logic        bus_rxd,
  input  logic        bus_ok,
  input  logic        if_fault,
  input  logic        can_txd,
  output logic [1:0]  can_state,
  output logic        can_tx_en,
  output logic        can_rxd_out,
  output logic        v2_en,
  output logic        lin_active,
  output logic        lin_tx_en,
  output logic        lin_low_slope,
  output logic        lin_hi_drive,
  output logic        lin_wake_en
);
  ctl_t    ctl;
  can_st_e st;
  logic    wr_fire, txoff_fall, clr_listen, wake_enter, expire, mode_ok, fault_q, run;

  assign mode_ok = (sys_mode == 2'b01) || (sys_mode == 2'b10);
  assign run     = (st == CS_ONLINE) || (st == CS_LISTEN);

  phyc_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frame_valid), .frm_ready(frame_ready), .frm_data(frame_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .gp_status(gp_status), .clr_listen(clr_listen), .ctl(ctl),
    .wr_fire(wr_fire), .txoff_fall(txoff_fall)
  );

  phyc_idle_timer #(
    .T_SHORT(T_SHORT), .T_LONG(T_LONG),
    .T_SHORT_EXT(T_SHORT_EXT), .T_LONG_EXT(T_LONG_EXT)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .bus_rxd(bus_rxd),
    .wake_set(wake_enter), .off_long(ctl.off_long), .expire(expire)
  );

  phyc_can_seq u_seq (
    .clk(clk), .rst_n(rst_n), .bus_wake(bus_wake), .mode_ok(mode_ok),
    .can_act(ctl.can_act), .listen_req(ctl.listen_req), .expire(expire),
    .state(st), .clr_listen(clr_listen), .wake_enter(wake_enter)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      fault_q <= 1'b0;
    else if (if_fault)               fault_q <= 1'b1;
    else if (bus_ok || txoff_fall)   fault_q <= 1'b0;
  end

  assign can_state     = st;
  assign can_tx_en     = (st == CS_ACTIVE) && !ctl.can_tx_off && !fault_q;
  assign can_rxd_out   = (ctl.can_loop && ctl.can_tx_off) ? can_txd : bus_rxd;
  assign v2_en         = (st != CS_OFFLINE) || ctl.v2_keep;
  assign lin_active    = ctl.lin_act && mode_ok;
  assign lin_tx_en     = lin_active && !ctl.lin_tx_off;
  assign lin_low_slope = ctl.lin_low_slope;
  assign lin_hi_drive  = ctl.lin_hi_drive;
  assign lin_wake_en   = ctl.lin_wake_en;

  p_expire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !bus_wake |=> can_state == 2'd0);

  p_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    if_fault |=> !can_tx_en);

  p_listen_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_listen && !wr_fire |=> !ctl.listen_req);

  p_loop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.can_tx_off |-> can_rxd_out == bus_rxd);

  p_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !frame_ready);
endmodule

// File: tb/test_phy_ctrl_reg.sv
module test_phy_ctrl_reg;
  localparam int CLK_P = 10;
  localparam int TS = 16, TL = 40, TSE = 24, TLE = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_valid = 0, resp_ready = 1, bus_wake = 0, bus_rxd = 1, bus_ok = 0;
  logic if_fault = 0, can_txd = 1;
  logic [15:0] frame_data = '0, gp_status = 16'h5A3C;
  logic [1:0]  sys_mode = 2'b00;
  logic frame_ready, resp_valid, can_tx_en, can_rxd_out, v2_en;
  logic lin_active, lin_tx_en, lin_low_slope, lin_hi_drive, lin_wake_en;
  logic [15:0] resp_data;
  logic [1:0]  can_state;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  phy_ctrl_reg #(.T_SHORT(TS), .T_LONG(TL), .T_SHORT_EXT(TSE), .T_LONG_EXT(TLE)) i_phy_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_ready(frame_ready),
    .frame_data(frame_data), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .gp_status(gp_status), .sys_mode(sys_mode),
    .bus_wake(bus_wake), .bus_rxd(bus_rxd), .bus_ok(bus_ok), .if_fault(if_fault),
    .can_txd(can_txd), .can_state(can_state), .can_tx_en(can_tx_en),
    .can_rxd_out(can_rxd_out), .v2_en(v2_en), .lin_active(lin_active),
    .lin_tx_en(lin_tx_en), .lin_low_slope(lin_low_slope),
    .lin_hi_drive(lin_hi_drive), .lin_wake_en(lin_wake_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d, input bit has_rsp, input logic [15:0] e, input string tag);
    if (has_rsp) begin exp_q.push_back(e); tag_q.push_back(tag); end
    frame_valid = 1'b1;
    frame_data  = d;
    #1;
    while (!frame_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic pulse_wake();
    bus_wake = 1'b1;
    @(negedge clk);
    bus_wake = 1'b0;
  endtask

  task automatic bus_toggle2();
    bus_rxd = 1'b0; @(negedge clk);
    bus_rxd = 1'b1; @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && resp_valid && resp_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected response actual=%h expected=none", resp_data);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (resp_data !== e) begin
            fails++;
            $display("FAIL %s response actual=%h expected=%h", t, resp_data, e);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R12 reset state
    chk("R12 state", can_state, 0);
    chk("R12 tx_en", can_tx_en, 0);
    chk("R12 v2_en (R13)", v2_en, 0);
    chk("R12 resp_valid", resp_valid, 0);
    chk("R12 frame_ready", frame_ready, 1);
    @(negedge clk);
    send(16'hD000, 1, 16'hC000, "R12 read ctl");
    // R1 foreign address
    send(16'h4FFF, 0, 16'h0, "R1");
    send(16'h8123, 0, 16'h0, "R1");
    send(16'hD000, 1, 16'hC000, "R1 unchanged");
    // R4 reserved, R13 keep-on
    send(16'hC820, 1, 16'hC000, "R2 write returns old");
    send(16'hD000, 1, 16'hC800, "R4 reserved reads 0");
    #1; chk("R13 v2 keep offline", v2_en, 1);
    chk("R4 no lin effect", lin_active, 0);
    // R2 read-only
    @(negedge clk);
    send(16'hD0FF, 1, 16'hC800, "R2 ro");
    send(16'hD000, 1, 16'hC800, "R2 unchanged");
    // R3 gp select
    send(16'hF000, 1, 16'h5A3C, "R3 gp");
    // R6 LIN gating
    send(16'hC810, 1, 16'hC800, "R6 write");
    sys_mode = 2'b00; #1; chk("R6 lin standby", lin_tx_en, 0);
    sys_mode = 2'b01; #1; chk("R6 lin normal", lin_tx_en, 1);
    sys_mode = 2'b10; #1; chk("R6 lin flash", lin_tx_en, 1);
    sys_mode = 2'b11; #1; chk("R6 lin sleep", lin_tx_en, 0);
    sys_mode = 2'b00;
    @(negedge clk);
    // R7 listen
    send(16'hCC10, 1, 16'hC810, "R7 write listen");
    pulse_wake();
    chk("R7 wake to listen", can_state, 2);
    sys_mode = 2'b01;
    send(16'hCC50, 1, 16'hCC10, "R7 write act");
    @(negedge clk);
    chk("R7 active", can_state, 3);
    #1; chk("R14 tx_en active", can_tx_en, 1);
    @(negedge clk);
    send(16'hD000, 1, 16'hC850, "R7 listen cleared on active");
    bus_toggle2();
    send(16'hCC50, 1, 16'hC850, "R7 write listen in active");
    @(negedge clk);
    send(16'hD000, 1, 16'hCC50, "R7 listen kept in active");
    sys_mode = 2'b00;
    @(negedge clk);
    chk("R7 to online", can_state, 1);
    @(negedge clk);
    send(16'hD000, 1, 16'hC850, "R7 listen cleared on online");
    // R9 short timeout
    sys_mode = 2'b01;
    @(negedge clk);
    chk("R6 active normal", can_state, 3);
    bus_toggle2();
    sys_mode = 2'b00;
    @(negedge clk);
    repeat (TS - 1) @(negedge clk);
    chk("R9 short still online", can_state, 1);
    @(negedge clk);
    chk("R9 short offline", can_state, 0);
    // R9 long timeout
    send(16'hCA50, 1, 16'hC850, "R9 write long");
    sys_mode = 2'b01;
    pulse_wake();
    @(negedge clk);
    chk("R9 active", can_state, 3);
    bus_toggle2();
    sys_mode = 2'b00;
    @(negedge clk);
    repeat (TL - 1) @(negedge clk);
    chk("R9 long still online", can_state, 1);
    @(negedge clk);
    chk("R9 long offline", can_state, 0);
    // R10 extended after wake
    send(16'hC850, 1, 16'hCA50, "R10 write short");
    pulse_wake();
    repeat (TSE - 1) @(negedge clk);
    chk("R10 ext still online", can_state, 1);
    @(negedge clk);
    chk("R10 ext offline", can_state, 0);
    pulse_wake();
    repeat (9) @(negedge clk);
    bus_rxd = 1'b0;
    @(negedge clk);
    repeat (TS - 1) @(negedge clk);
    chk("R10 restart still online", can_state, 1);
    @(negedge clk);
    chk("R10 restart offline", can_state, 0);
    // R8 loopback
    send(16'hC980, 1, 16'hC850, "R8 write loop+txoff");
    bus_rxd = 1'b1; can_txd = 1'b0; #1;
    chk("R8 loop txd0", can_rxd_out, 0);
    can_txd = 1'b1; #1;
    chk("R8 loop txd1", can_rxd_out, 1);
    @(negedge clk);
    send(16'hC880, 1, 16'hC980, "R8 write loop only");
    can_txd = 1'b0; #1;
    chk("R8 no loop bus1", can_rxd_out, 1);
    bus_rxd = 1'b0; can_txd = 1'b1; #1;
    chk("R8 no loop bus0", can_rxd_out, 0);
    @(negedge clk);
    // R11 fault latch
    send(16'hC840, 1, 16'hC880, "R11 write act");
    sys_mode = 2'b01;
    pulse_wake();
    @(negedge clk);
    chk("R11 active", can_state, 3);
    chk("R14 tx before fault", can_tx_en, 1);
    if_fault = 1'b1; @(negedge clk); if_fault = 1'b0;
    chk("R11 fault disables", can_tx_en, 0);
    send(16'hD000, 1, 16'hC840, "R11 bit untouched");
    bus_ok = 1'b1; @(negedge clk); bus_ok = 1'b0;
    chk("R11 traffic recovers", can_tx_en, 1);
    if_fault = 1'b1; @(negedge clk); if_fault = 1'b0;
    chk("R11 fault again", can_tx_en, 0);
    send(16'hC940, 1, 16'hC840, "R11 set txoff");
    chk("R11 txoff held", can_tx_en, 0);
    send(16'hC840, 1, 16'hC940, "R11 clear txoff");
    chk("R11 sw recovers", can_tx_en, 1);
    sys_mode = 2'b10;
    @(negedge clk);
    chk("R6 flash keeps active", can_state, 3);
    sys_mode = 2'b11;
    @(negedge clk);
    chk("R6 sleep leaves active", can_state, 1);
    chk("R14 tx off online", can_tx_en, 0);
    sys_mode = 2'b00;
    // R5 back-pressure
    resp_ready = 1'b0;
    send(16'hD000, 1, 16'hC840, "R5 held response");
    #1;
    chk("R5 resp_valid held", resp_valid, 1);
    chk("R5 frame_ready low", frame_ready, 0);
    repeat (3) @(negedge clk);
    #1;
    chk("R5 data stable", resp_data, 16'hC840);
    @(negedge clk);
    resp_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule